// File: doc/BRIEF.md
# Byte ALU with Status Flags

This unit is the arithmetic and logic stage of a small 8-bit processor core, together with the processor's status byte. Each cycle the sequencer presents an operation code, a register operand (the accumulator, or the X or Y index register for compares, shifts and counts) and a memory operand. The unit returns the operation's result and the status byte that the operation would produce. When the flag-write strobe is high, that status byte is stored into the held status register on the next rising clock edge.

Each operation changes only the flags it defines. Add and subtract share one binary adder, and the decimal flag never changes how it works. Compare is a subtraction whose difference is discarded. Bit test copies the two top memory bits into the overflow and negative flags. Shifts and rotates move a bit through carry. Increment, decrement, load and the bitwise operations touch only zero and negative. A few flag operations (set carry, clear carry, clear overflow, restore the whole byte) let the sequencer place the status register in any state. Addressing, sequencing and writeback stay outside the unit.

The status byte layout is fixed: carry at bit 0, zero at bit 1, interrupt mask at bit 2, decimal at bit 3, break at bit 4, an unused bit at bit 5, overflow at bit 6 and negative at bit 7.

Top module: `alu_flags_unit`

## Requirements
- R1: The status byte layout is C=bit0, Z=bit1, I=bit2, D=bit3, B=bit4, U=bit5, V=bit6, N=bit7. While reset is low, status_q is STATUS_RST (default 8'h34).
- R2: Op 0 (add) gives result = reg+mem+C over 8 bits. C is bit 8 of that 9-bit sum. Z is set when the result is zero. N is result bit 7. V is set when both operands have the same sign and the result has the other sign. I, D, B and U are kept.
- R3: Op 1 (subtract) gives result = reg+~mem+C. C is set when no borrow occurs. V is computed as for an add of ~mem. Z and N come from the result. The D flag never changes this operation.
- R4: Op 2 (compare) sets C when reg>=mem (unsigned), sets Z when reg==mem, and sets N from bit 7 of reg-mem. V, I and D are kept, and result equals reg_in.
- R5: Ops 3 (AND), 4 (OR), 5 (XOR) and 13 (load, result = mem) change only Z and N.
- R6: Op 6 (bit test) sets Z when (reg AND mem)==0, copies mem bit 6 into V and mem bit 7 into N, keeps C, and leaves result equal to reg_in.
- R7: Op 7 (shift left) fills bit 0 with zero and loads C from bit 7. Op 8 (shift right) fills bit 7 with zero, loads C from bit 0 and always clears N.
- R8: Op 9 (rotate left) moves the old C into bit 0, and op 10 (rotate right) moves it into bit 7. In both, the bit shifted out becomes the new C.
- R9: Op 11 (increment) and op 12 (decrement) wrap modulo 256 and change only Z and N.
- R10: Op 14 sets C, op 15 clears C and op 16 clears V. Op 17 restores the status byte from mem with bits 4 and 5 forced to zero. All four leave result equal to reg_in.
- R11: With flag_we low, status_q keeps its value across a clock edge while status_next still shows the computed byte.
- R12: With flag_we high, status_q takes the value of status_next on the next rising edge. Codes 18 to 31 are no-ops: result = reg_in and status_next = status_q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 5 | Operation code |
| reg_in | input | DATA_W | Register operand (accumulator, X or Y) |
| mem_in | input | DATA_W | Memory operand |
| flag_we | input | 1 | Status write strobe |
| result | output | DATA_W | Operation result |
| status_next | output | 8 | Status byte the operation produces |
| status_q | output | 8 | Held status register |

## Verification
The bench builds the unit with its defaults: DATA_W of 8 and STATUS_RST of 8'h34. At that width the byte boundaries can be reached directly: wrap from 8'hFF to zero, a carry out of bit 7, sign changes that raise overflow, and the bit-6 and bit-7 copies made by bit test. Before each vector, the restore operation loads an exact starting status byte. This puts carry-in, the decimal flag and the untouched flags in known states, so any flag an operation should not change would show up as a mismatch.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    localparam int STATUS_W = 8;

    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_I = 2;
    localparam int FLAG_D = 3;
    localparam int FLAG_B = 4;
    localparam int FLAG_U = 5;
    localparam int FLAG_V = 6;
    localparam int FLAG_N = 7;

    typedef enum logic [4:0] {
        OP_ADC     = 5'd0,
        OP_SBC     = 5'd1,
        OP_CMP     = 5'd2,
        OP_AND     = 5'd3,
        OP_ORA     = 5'd4,
        OP_EOR     = 5'd5,
        OP_BIT     = 5'd6,
        OP_ASL     = 5'd7,
        OP_LSR     = 5'd8,
        OP_ROL     = 5'd9,
        OP_ROR     = 5'd10,
        OP_INC     = 5'd11,
        OP_DEC     = 5'd12,
        OP_LOAD    = 5'd13,
        OP_SETC    = 5'd14,
        OP_CLRC    = 5'd15,
        OP_CLRV    = 5'd16,
        OP_RESTORE = 5'd17
    } alu_op_e;

endpackage

// File: rtl/alu_add_core.sv
module alu_add_core #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         invert_b,
    input  logic         carry_in,
    output logic [W-1:0] sum_out,
    output logic         carry_out,
    output logic         ovf_out
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff     = invert_b ? ~b_in : b_in;
        full      = {1'b0, a_in} + {1'b0, b_eff} + {{W{1'b0}}, carry_in};
        sum_out   = full[W-1:0];
        carry_out = full[W];
        // operands agree in sign, sum disagrees
        ovf_out   = (a_in[W-1] == b_eff[W-1]) && (full[W-1] != a_in[W-1]);
    end
endmodule

// File: rtl/alu_logic_core.sv
module alu_logic_core
    import alu_flags_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      sel,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] m_in,
    output logic [W-1:0] res_out
);
    always_comb begin
        unique case (sel)
            OP_AND, OP_BIT: res_out = a_in & m_in;
            OP_ORA:         res_out = a_in | m_in;
            OP_EOR:         res_out = a_in ^ m_in;
            OP_LOAD:        res_out = m_in;
            default:        res_out = a_in;
        endcase
    end
endmodule

// File: rtl/alu_shift_core.sv
module alu_shift_core
    import alu_flags_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      sel,
    input  logic [W-1:0] val_in,
    input  logic         carry_in,
    output logic [W-1:0] res_out,
    output logic         carry_out
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (sel)
            OP_ASL: begin
                res_out   = {val_in[W-2:0], 1'b0};
                carry_out = val_in[W-1];
            end
            OP_LSR: begin
                res_out   = {1'b0, val_in[W-1:1]};
                carry_out = val_in[0];
            end
            OP_ROL: begin
                res_out   = {val_in[W-2:0], carry_in};
                carry_out = val_in[W-1];
            end
            OP_ROR: begin
                res_out   = {carry_in, val_in[W-1:1]};
                carry_out = val_in[0];
            end
            OP_INC: begin
                res_out   = val_in + ONE;
                carry_out = carry_in;
            end
            OP_DEC: begin
                res_out   = val_in - ONE;
                carry_out = carry_in;
            end
            default: begin
                res_out   = val_in;
                carry_out = carry_in;
            end
        endcase
    end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
#(
    parameter int                    DATA_W     = 8,
    parameter logic [STATUS_W-1:0]   STATUS_RST = 8'h34
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [4:0]           op_sel,
    input  logic [DATA_W-1:0]    reg_in,
    input  logic [DATA_W-1:0]    mem_in,
    input  logic                 flag_we,
    output logic [DATA_W-1:0]    result,
    output logic [STATUS_W-1:0]  status_next,
    output logic [STATUS_W-1:0]  status_q
);
    localparam int MSB = DATA_W - 1;

    alu_op_e          op_e;
    logic             add_invert;
    logic             add_cin;
    logic [MSB:0]     add_sum;
    logic             add_cout;
    logic             add_ovf;
    logic [MSB:0]     logic_res;
    logic [MSB:0]     shift_res;
    logic             shift_cout;

    assign op_e       = alu_op_e'(op_sel);
    assign add_invert = (op_e != OP_ADC);
    assign add_cin    = (op_e == OP_CMP) ? 1'b1 : status_q[FLAG_C];

    alu_add_core #(.W(DATA_W)) u_add (
        .a_in      (reg_in),
        .b_in      (mem_in),
        .invert_b  (add_invert),
        .carry_in  (add_cin),
        .sum_out   (add_sum),
        .carry_out (add_cout),
        .ovf_out   (add_ovf)
    );

    alu_logic_core #(.W(DATA_W)) u_logic (
        .sel     (op_e),
        .a_in    (reg_in),
        .m_in    (mem_in),
        .res_out (logic_res)
    );

    alu_shift_core #(.W(DATA_W)) u_shift (
        .sel       (op_e),
        .val_in    (reg_in),
        .carry_in  (status_q[FLAG_C]),
        .res_out   (shift_res),
        .carry_out (shift_cout)
    );

    // status register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= STATUS_RST;
        end else if (flag_we) begin
            status_q <= status_next;
        end
    end

    // output process
    always_comb begin
        result      = reg_in;
        status_next = status_q;
        unique case (op_e)
            OP_ADC, OP_SBC: begin
                result              = add_sum;
                status_next[FLAG_C] = add_cout;
                status_next[FLAG_Z] = (add_sum == '0);
                status_next[FLAG_V] = add_ovf;
                status_next[FLAG_N] = add_sum[MSB];
            end
            OP_CMP: begin
                status_next[FLAG_C] = add_cout;
                status_next[FLAG_Z] = (reg_in == mem_in);
                status_next[FLAG_N] = add_sum[MSB];
            end
            OP_AND, OP_ORA, OP_EOR, OP_LOAD: begin
                result              = logic_res;
                status_next[FLAG_Z] = (logic_res == '0);
                status_next[FLAG_N] = logic_res[MSB];
            end
            OP_BIT: begin
                status_next[FLAG_Z] = (logic_res == '0);
                status_next[FLAG_V] = mem_in[MSB-1];
                status_next[FLAG_N] = mem_in[MSB];
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                result              = shift_res;
                status_next[FLAG_C] = shift_cout;
                status_next[FLAG_Z] = (shift_res == '0);
                status_next[FLAG_N] = shift_res[MSB];
            end
            OP_INC, OP_DEC: begin
                result              = shift_res;
                status_next[FLAG_Z] = (shift_res == '0);
                status_next[FLAG_N] = shift_res[MSB];
            end
            OP_SETC: status_next[FLAG_C] = 1'b1;
            OP_CLRC: status_next[FLAG_C] = 1'b0;
            OP_CLRV: status_next[FLAG_V] = 1'b0;
            OP_RESTORE: begin
                status_next         = mem_in[STATUS_W-1:0];
                status_next[FLAG_B] = 1'b0;
                status_next[FLAG_U] = 1'b0;
            end
            default: begin
                result      = reg_in;
                status_next = status_q;
            end
        endcase
    end
endmodule

// File: rtl/alu_flags_checker.sv
module alu_flags_checker
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [4:0]          op_sel,
    input logic [DATA_W-1:0]   reg_in,
    input logic [DATA_W-1:0]   mem_in,
    input logic                flag_we,
    input logic [DATA_W-1:0]   result,
    input logic [STATUS_W-1:0] status_next,
    input logic [STATUS_W-1:0] status_q
);
    logic zn_only_op;
    assign zn_only_op = (op_sel == OP_AND) || (op_sel == OP_ORA) || (op_sel == OP_EOR) ||
                        (op_sel == OP_LOAD) || (op_sel == OP_INC) || (op_sel == OP_DEC);

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(status_q)); // R11

    AST_STROBE_LOADS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (status_q == $past(status_next))); // R12

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CMP) |-> (result == reg_in)); // R4

    AST_BIT_COPIES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_BIT) |-> ((status_next[FLAG_N] == mem_in[DATA_W-1]) &&
                                (status_next[FLAG_V] == mem_in[DATA_W-2]))); // R6

    AST_ZN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        zn_only_op |-> (((status_next ^ status_q) & 8'h7D) == 8'h00)); // R5

    AST_LSR_CLEARS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_LSR) |-> !status_next[FLAG_N]); // R7

    AST_RESTORE_DROPS_BU: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_RESTORE) |-> (!status_next[FLAG_B] && !status_next[FLAG_U] &&
                                    (result == reg_in))); // R10
endmodule

bind alu_flags_unit alu_flags_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_sel      (op_sel),
    .reg_in      (reg_in),
    .mem_in      (mem_in),
    .flag_we     (flag_we),
    .result      (result),
    .status_next (status_next),
    .status_q    (status_q)
);

// File: tb/test_alu_flags_unit.sv
module test_alu_flags_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_sel = 5'd31;
    logic [7:0] reg_in = 8'h00;
    logic [7:0] mem_in = 8'h00;
    logic       flag_we = 1'b0;
    logic [7:0] result;
    logic [7:0] status_next;
    logic [7:0] status_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    alu_flags_unit i_alu_flags_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_sel      (op_sel),
        .reg_in      (reg_in),
        .mem_in      (mem_in),
        .flag_we     (flag_we),
        .result      (result),
        .status_next (status_next),
        .status_q    (status_q)
    );

    // {req[4], op[5], reg[8], mem[8], start status[8], exp result[8], exp status[8]}
    localparam int NVEC = 27;
    localparam logic [48:0] VEC [NVEC] = '{
        {4'd2,  5'd0,  8'h50, 8'h50, 8'h00, 8'hA0, 8'hC0}, // R2 signed overflow
        {4'd2,  5'd0,  8'hFF, 8'h01, 8'h01, 8'h01, 8'h01}, // R2 carry in and out
        {4'd2,  5'd0,  8'h80, 8'h80, 8'h04, 8'h00, 8'h47}, // R2 zero, carry, overflow, I kept
        {4'd3,  5'd1,  8'h50, 8'hF0, 8'h01, 8'h60, 8'h00}, // R3 borrow
        {4'd3,  5'd1,  8'h50, 8'hB0, 8'h01, 8'hA0, 8'hC0}, // R3 overflow
        {4'd3,  5'd1,  8'h10, 8'h05, 8'h08, 8'h0A, 8'h09}, // R3 D set, binary, carry clear in
        {4'd3,  5'd1,  8'h00, 8'h00, 8'h01, 8'h00, 8'h03}, // R3 zero no borrow
        {4'd4,  5'd2,  8'h40, 8'h40, 8'h44, 8'h40, 8'h47}, // R4 equal
        {4'd4,  5'd2,  8'h10, 8'h20, 8'h01, 8'h10, 8'h80}, // R4 less
        {4'd5,  5'd3,  8'hF0, 8'h0F, 8'hC1, 8'h00, 8'h43}, // R5 AND
        {4'd5,  5'd4,  8'h01, 8'h80, 8'h43, 8'h81, 8'hC1}, // R5 OR
        {4'd5,  5'd5,  8'hFF, 8'hFF, 8'h80, 8'h00, 8'h02}, // R5 XOR
        {4'd5,  5'd13, 8'h12, 8'h00, 8'h81, 8'h00, 8'h03}, // R5 load
        {4'd6,  5'd6,  8'h0F, 8'hC0, 8'h01, 8'h0F, 8'hC3}, // R6 copies
        {4'd6,  5'd6,  8'hFF, 8'h01, 8'hC2, 8'hFF, 8'h00}, // R6 clears
        {4'd7,  5'd7,  8'h81, 8'h00, 8'h00, 8'h02, 8'h01}, // R7 shift left
        {4'd7,  5'd8,  8'h01, 8'h00, 8'h80, 8'h00, 8'h03}, // R7 shift right
        {4'd8,  5'd9,  8'h80, 8'h00, 8'h01, 8'h01, 8'h01}, // R8 rotate left
        {4'd8,  5'd10, 8'h01, 8'h00, 8'h01, 8'h80, 8'h81}, // R8 rotate right carry in
        {4'd8,  5'd10, 8'h02, 8'h00, 8'h00, 8'h01, 8'h00}, // R8 rotate right no carry
        {4'd9,  5'd11, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h03}, // R9 increment wrap
        {4'd9,  5'd12, 8'h00, 8'h00, 8'h40, 8'hFF, 8'hC0}, // R9 decrement wrap
        {4'd10, 5'd14, 8'h33, 8'h00, 8'h00, 8'h33, 8'h01}, // R10 set C
        {4'd10, 5'd15, 8'h33, 8'h00, 8'hC3, 8'h33, 8'hC2}, // R10 clear C
        {4'd10, 5'd16, 8'h33, 8'h00, 8'hC3, 8'h33, 8'h83}, // R10 clear V
        {4'd10, 5'd17, 8'h55, 8'hFF, 8'h00, 8'h55, 8'hCF}, // R10 restore drops bits 4,5
        {4'd12, 5'd20, 8'h66, 8'h00, 8'h4D, 8'h66, 8'h4D}  // R12 unused code
    };

    task automatic check8(input int req, input string what, input logic [7:0] act,
                          input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic restore(input logic [7:0] st);
        @(negedge clk);
        op_sel  = 5'd17;
        mem_in  = st;
        flag_we = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check8(1, "reset status", status_q, 8'h34); // R1
        rst_n = 1'b1;
        @(negedge clk);
        check8(1, "status after release, strobe low", status_q, 8'h34); // R1

        for (int i = 0; i < NVEC; i++) begin
            restore(VEC[i][23:16]);
            op_sel  = VEC[i][44:40];
            reg_in  = VEC[i][39:32];
            mem_in  = VEC[i][31:24];
            flag_we = 1'b1;
            #1;
            check8(int'(VEC[i][48:45]), $sformatf("vec %0d result", i), result, VEC[i][15:8]);
            check8(int'(VEC[i][48:45]), $sformatf("vec %0d status_next", i), status_next,
                   VEC[i][7:0]);
            @(negedge clk);
            check8(12, $sformatf("vec %0d status_q", i), status_q, VEC[i][7:0]);
        end

        // R11: strobe low holds the register while status_next shows the result
        restore(8'h00);
        op_sel  = 5'd0;
        reg_in  = 8'hFF;
        mem_in  = 8'h01;
        flag_we = 1'b0;
        #1;
        check8(11, "status_next with strobe low", status_next, 8'h03);
        @(negedge clk);
        check8(11, "status_q held", status_q, 8'h00);
        @(negedge clk);
        check8(11, "status_q still held", status_q, 8'h00);
        // R12: raise the strobe on the same operation
        flag_we = 1'b1;
        @(negedge clk);
        check8(12, "status_q loaded", status_q, 8'h03);

        // R3: D flag set with carry set gives plain binary 0x19-0x09
        restore(8'h09);
        op_sel = 5'd1;
        reg_in = 8'h19;
        mem_in = 8'h09;
        #1;
        check8(3, "binary subtract with D", result, 8'h10);

        // R1: asynchronous reset mid-run
        flag_we = 1'b0;
        rst_n = 1'b0;
        #1;
        check8(1, "async reset value", status_q, 8'h34);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule